// File: doc/BRIEF.md
# Memory Refresh Interval Timer

This block sets the pace of periodic memory refresh and can double as an interval timer that raises an interrupt. An 8-bit up-counter advances on an externally supplied prescaled tick, provided a clock-select field in the control word is nonzero. When the counter equals a programmable compare value, the next enabled tick clears the counter instead of advancing it. That same event sets a compare-match flag and, if refresh is enabled, raises a refresh request towards the memory controller.

The refresh request stays high until the memory controller acknowledges it. It is unaffected by the interrupt flag. Matches that occur while a request is already pending are not counted. The interrupt output follows the flag while the interrupt enable is set. Software clears the flag by reading the control word with the flag set and then writing 0 to the flag bit. Writes to the counter and to the compare value are guarded by a 16-bit key in the upper half of the write data.

Top module: `rfsh_timer`

## Requirements
- R1: After reset the counter, the compare value, the control word (select, enables, flag), `rfsh_req`, `irq` and `reg_rdata` are all 0.
- R2: The counter rises by one on each cycle where `tick` is 1 and the clock-select field (control bits 2:0) is nonzero. With `tick` at 0 or the select field at 0, the counter holds.
- R3: On an enabled tick while the counter equals the compare value, the counter becomes 0 instead of incrementing, and the flag (control bit 7) becomes 1.
- R4: When no match occurs, the counter goes from 255 to 0 on an enabled tick, and the flag stays unchanged.
- R5: A write to the counter (select 1) or to the compare value (select 2) takes effect only when write data bits 31:16 equal 16'hA55A. Any other write leaves the register unchanged.
- R6: A read with select 0, 1 or 2 returns the control word, the counter or the compare value on `reg_rdata` in the cycle after `reg_rd`. Bits 31:8 of the returned value are 0. Select 3 returns 0. The control word holds select in bits 2:0, refresh enable in bit 3, interrupt enable in bit 4 and the flag in bit 7, with bits 6:5 reading 0.
- R7: When refresh enable is 1, a match sets `rfsh_req` on the next cycle. The request stays at 1 until a cycle with `rfsh_ack` at 1.
- R8: Matches that occur while `rfsh_req` is already 1 are dropped. A single acknowledge clears the request, no matter how many matches occurred meanwhile.
- R9: `irq` equals the flag ANDed with the interrupt enable, from the same clock edge.
- R10: A control write with bit 7 at 0 clears the flag only if the flag was read as 1 since the last control write. Writing 1 to bit 7 has no effect. Clearing the flag leaves `rfsh_req` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 counter, 2 compare, 3 unused |
| reg_wdata | input | 32 | Write data; bits 31:16 carry the key for counter and compare writes |
| reg_rdata | output | 32 | Registered read data |
| tick | input | 1 | Prescaled count enable |
| rfsh_ack | input | 1 | Refresh acknowledge from the memory controller |
| rfsh_req | output | 1 | Pending refresh request |
| irq | output | 1 | Compare-match interrupt |

## Verification
The assertions assume that software never issues a read and a write in the same cycle. They also assume that a keyed counter load and an enabled tick do not coincide when the hold and match-clear properties are examined; those properties exclude load cycles. The stimulus drives one register access per task call and sets `tick` to 0 during every access, so ticks and accesses never overlap. Acknowledges are issued only in cycles without a tick, so the request-hold property is never checked against a same-cycle match.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CMP  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rfsh_counter.sv
module rfsh_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             cnt_ld,
  input  logic             cmp_ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic             match
);
  assign match = tick_en && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      cmp <= '0;
    end else begin
      if (cnt_ld)       cnt <= ld_val;
      else if (match)   cnt <= '0;
      else if (tick_en) cnt <= cnt + 1'b1;
      if (cmp_ld)       cmp <= ld_val;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !cnt_ld) |=> $stable(cnt)); // R2
  AST_MATCH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (match && !cnt_ld) |=> (cnt == '0)); // R3
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cmp_ld |=> $stable(cmp)); // R5
endmodule

// File: rtl/rfsh_status.sv
module rfsh_status #(
  parameter int CKS_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_rd,
  input  logic [CKS_W-1:0] wr_cks,
  input  logic             wr_ren,
  input  logic             wr_ie,
  input  logic             wr_flag,
  input  logic             match,
  input  logic             rfsh_ack,
  output logic [CKS_W-1:0] cks,
  output logic             ren,
  output logic             ie,
  output logic             flag,
  output logic             rfsh_req,
  output logic             irq
);
  logic armed;
  logic flag_clr;
  logic flag_d;
  logic ie_d;

  assign flag_clr = ctl_wr && armed && !wr_flag;
  assign flag_d   = match || (flag && !flag_clr);
  assign ie_d     = ctl_wr ? wr_ie : ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      cks      <= '0;
      ren      <= 1'b0;
      ie       <= 1'b0;
      flag     <= 1'b0;
      armed    <= 1'b0;
      rfsh_req <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (ctl_wr) begin
        cks <= wr_cks;
        ren <= wr_ren;
        ie  <= wr_ie;
      end
      flag <= flag_d;
      if (ctl_wr)              armed <= 1'b0;
      else if (ctl_rd && flag) armed <= 1'b1;
      rfsh_req <= (rfsh_req && !rfsh_ack) || (match && ren);
      irq      <= flag_d && ie_d;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rfsh_req && !rfsh_ack) |=> rfsh_req); // R7
  AST_REQ_ACK: assert property (@(posedge clk) disable iff (rst)
    (rfsh_ack && !match) |=> !rfsh_req); // R8
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    match |=> flag); // R3
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && ie)); // R9
  AST_FLAG_W1: assert property (@(posedge clk) disable iff (rst)
    (flag && ctl_wr && wr_flag) |=> flag); // R10
endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int          DATA_W = 32,
  parameter int          CNT_W  = 8,
  parameter int          CKS_W  = 3,
  parameter int          KEY_W  = 16,
  parameter logic [15:0] KEY    = 16'hA55A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick,
  input  logic              rfsh_ack,
  output logic              rfsh_req,
  output logic              irq
);
  import rfsh_pkg::*;

  localparam int REN_BIT  = CKS_W;
  localparam int IE_BIT   = CKS_W + 1;
  localparam int FLAG_BIT = CNT_W - 1;

  logic [CNT_W-1:0]  cnt, cmp;
  logic [CKS_W-1:0]  cks;
  logic              ren, ie, flag, match, tick_en, key_ok;
  logic              cnt_ld, cmp_ld, ctl_wr, ctl_rd;
  logic [DATA_W-1:0] rd_mux;
  reg_sel_e          sel;

  assign sel     = reg_sel_e'(reg_sel);
  assign tick_en = tick && (cks != '0);
  assign key_ok  = (reg_wdata[DATA_W-1 -: KEY_W] == KEY[KEY_W-1:0]);
  assign cnt_ld  = reg_wr && key_ok && (sel == SEL_CNT);
  assign cmp_ld  = reg_wr && key_ok && (sel == SEL_CMP);
  assign ctl_wr  = reg_wr && (sel == SEL_CTRL);
  assign ctl_rd  = reg_rd && (sel == SEL_CTRL);

  rfsh_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_ld(cnt_ld), .cmp_ld(cmp_ld),
    .ld_val(reg_wdata[CNT_W-1:0]), .cnt(cnt), .cmp(cmp), .match(match)
  );

  rfsh_status #(.CKS_W(CKS_W)) u_stat (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .wr_cks(reg_wdata[CKS_W-1:0]), .wr_ren(reg_wdata[REN_BIT]),
    .wr_ie(reg_wdata[IE_BIT]), .wr_flag(reg_wdata[FLAG_BIT]),
    .match(match), .rfsh_ack(rfsh_ack), .cks(cks), .ren(ren), .ie(ie),
    .flag(flag), .rfsh_req(rfsh_req), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL: begin
        rd_mux[CKS_W-1:0] = cks;
        rd_mux[REN_BIT]   = ren;
        rd_mux[IE_BIT]    = ie;
        rd_mux[FLAG_BIT]  = flag;
      end
      SEL_CNT:  rd_mux[CNT_W-1:0] = cnt;
      SEL_CMP:  rd_mux[CNT_W-1:0] = cmp;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_RDATA_UPPER: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:CNT_W] == '0); // R6
  AST_NOKEY_CNT: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !key_ok && !tick_en) |=> $stable(cnt)); // R5
  AST_NOTICK_NOREQ: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !rfsh_req) |=> !rfsh_req); // R7
endmodule

// File: tb/rfsh_timer_bench.sv
`timescale 1ns/1ps
module rfsh_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, tick = 1'b0, rfsh_ack = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rfsh_req, irq;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  int m_cnt, m_cmp, m_cks, m_ren, m_ie, m_flag, m_armed, m_req, m_irq, m_rdata;

  always #2 clk = ~clk;

  rfsh_timer u_rfsh_timer (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
    .rfsh_ack(rfsh_ack), .rfsh_req(rfsh_req), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_cks = 0; m_ren = 0; m_ie = 0;
      m_flag = 0; m_armed = 0; m_req = 0; m_irq = 0; m_rdata = 0;
    end else begin
      int en, mt, key, nflag;
      en  = (tick && m_cks != 0) ? 1 : 0;
      mt  = (en && m_cnt == m_cmp) ? 1 : 0;
      key = (reg_wdata[31:16] == 16'hA55A) ? 1 : 0;
      if (reg_rd) begin
        case (reg_sel)
          2'd0: m_rdata = (m_flag << 7) | (m_ie << 4) | (m_ren << 3) | m_cks;
          2'd1: m_rdata = m_cnt;
          2'd2: m_rdata = m_cmp;
          default: m_rdata = 0;
        endcase
      end
      nflag = m_flag;
      if (reg_wr && reg_sel == 2'd0 && m_armed && !reg_wdata[7]) nflag = 0;
      if (mt) nflag = 1;
      if (reg_wr && reg_sel == 2'd0) m_armed = 0;
      else if (reg_rd && reg_sel == 2'd0 && m_flag) m_armed = 1;
      m_req = ((m_req && !rfsh_ack) || (mt && m_ren)) ? 1 : 0;
      if (mt) m_cnt = 0;
      else if (en) m_cnt = (m_cnt + 1) % 256;
      if (reg_wr && key && reg_sel == 2'd1) m_cnt = reg_wdata[7:0];
      if (reg_wr && key && reg_sel == 2'd2) m_cmp = reg_wdata[7:0];
      if (reg_wr && reg_sel == 2'd0) begin
        m_cks = reg_wdata[2:0]; m_ren = reg_wdata[3]; m_ie = reg_wdata[4];
      end
      m_flag = nflag;
      m_irq  = (m_flag && m_ie) ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R7 rfsh_req vs model", {31'd0, rfsh_req}, m_req);
      check("R9 irq vs model", {31'd0, irq}, m_irq);
      check("R6 reg_rdata vs model", reg_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d; tick = 1'b0;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_sel = s; tick = 1'b0;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic ack;
    @(negedge clk); rfsh_ack = 1'b1; tick = 1'b0;
    @(negedge clk); rfsh_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset irq", {31'd0, irq}, 0);
    check("R1 reset rfsh_req", {31'd0, rfsh_req}, 0);
    rd(2'd0, v); check("R1 reset ctrl", v, 32'h0);
    rd(2'd1, v); check("R1 reset counter", v, 32'h0);
    rd(2'd2, v); check("R1 reset compare", v, 32'h0);

    wr(2'd2, 32'h1234_0005); rd(2'd2, v); check("R5 compare bad key ignored", v, 32'h0);
    wr(2'd2, 32'hA55A_0005); rd(2'd2, v); check("R5 compare keyed write", v, 32'h5);

    wr(2'd0, 32'h0000_0018);
    ticks(3); rd(2'd1, v); check("R2 select zero gates tick", v, 32'h0);

    wr(2'd0, 32'hFFFF_FF19); rd(2'd0, v); check("R6 ctrl readback zero bits", v, 32'h19);
    ticks(5); rd(2'd1, v); check("R2 counter after five ticks", v, 32'h5);
    repeat (3) @(negedge clk);
    rd(2'd1, v); check("R2 no tick holds counter", v, 32'h5);
    ticks(1);
    check("R7 request raised on match", {31'd0, rfsh_req}, 1);
    check("R9 irq on match", {31'd0, irq}, 1);
    rd(2'd1, v); check("R3 counter cleared on match", v, 32'h0);
    rd(2'd0, v); check("R3 flag set", v, 32'h99);

    ticks(12);
    check("R8 request still single", {31'd0, rfsh_req}, 1);
    ack;
    check("R8 one ack clears request", {31'd0, rfsh_req}, 0);

    wr(2'd0, 32'h0000_0099);
    check("R10 writing 1 keeps flag", {31'd0, irq}, 1);
    wr(2'd0, 32'h0000_0019);
    check("R10 write 0 without read keeps flag", {31'd0, irq}, 1);
    ticks(6);
    check("R7 new request", {31'd0, rfsh_req}, 1);
    rd(2'd0, v); check("R10 flag read as 1", v, 32'h99);
    wr(2'd0, 32'h0000_0019);
    check("R10 flag clear drops irq", {31'd0, irq}, 0);
    check("R10 flag clear keeps request", {31'd0, rfsh_req}, 1);
    rd(2'd0, v); check("R10 flag cleared", v, 32'h19);
    ack;

    wr(2'd0, 32'h0000_0009);
    ticks(6);
    check("R9 irq masked when disabled", {31'd0, irq}, 0);
    rd(2'd0, v); check("R9 flag set though masked", v, 32'h89);
    ack;

    wr(2'd2, 32'hA55A_000A);
    wr(2'd1, 32'hA55A_00FA);
    rd(2'd1, v); check("R5 counter keyed write", v, 32'hFA);
    ticks(8); rd(2'd1, v); check("R4 counter wraps", v, 32'h2);
    wr(2'd1, 32'h0000_0077); rd(2'd1, v); check("R5 counter bad key ignored", v, 32'h2);
    rd(2'd3, v); check("R6 unused select reads 0", v, 32'h0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule